// File: doc/BRIEF.md
# Compare-Paced A/D Conversion Sequencer

This block paces analog sampling from a free-running timer. A 16-bit counter runs against a 16-bit compare value. When a 4-bit mode field selects the special-event mode and the counter reaches the compare value, the counter restarts from zero. The sampling period is therefore the compare value plus one clock. If the converter is enabled, the same event also raises the busy/start bit, GO.

While GO is set, a sequencer waits out an acquisition window chosen by a 3-bit code. It then sends a one-cycle start strobe, together with the selected channel, to an external converter. When the converter returns its 10-bit sample, the sequencer drops GO. In the same cycle it stores the sample as a high byte and a low byte, justified left or right, and sets a sticky done flag. Software can also start the same sequence by setting GO itself, which leaves the timer alone. Software must read the two result bytes before the next completion overwrites them.

Top module: `cmp_adc_seq`

## Requirements
- R1: After reset the timer, GO, the done flag and both result bytes are zero. The timer then increases by one on every clock and wraps from all ones to zero.
- R2: When the mode field holds 4'b1011 and the timer equals the compare value, the timer is zero on the next clock. With any other mode value the timer counts past the compare value.
- R3: A special event while the enable input is high and GO is low sets GO on the same clock edge that clears the timer.
- R4: While the enable input is low, neither special events nor software starts set GO, and no start strobe is issued. Special events still clear the timer.
- R5: Acquisition codes 0 to 7 give 0, 2, 4, 6, 8, 12, 16 and 20 periods of TAD_CYC clocks. The start strobe is high for exactly one cycle, that many cycles after the first cycle in which GO is high.
- R6: The channel output equals the channel-select input while the start strobe is high.
- R7: A special event while GO is high still clears the timer, but it does not issue another start strobe for the conversion in progress.
- R8: A one-cycle software start while enabled and idle sets GO on the next clock, and the timer keeps counting instead of being cleared.
- R9: When the converter's valid input is high while the sequencer waits for data, GO clears, the done flag sets and both result bytes load, all on that same clock edge.
- R10: With the left-justify input low, the high byte holds sample bits 9:8 in its bits 1:0 with zeros above, and the low byte holds bits 7:0. With it high, the high byte holds bits 9:2, and the low byte holds bits 1:0 in its bits 7:6 with zeros below.
- R11: The done flag stays set, and the result bytes stay unchanged, until a flag-clear pulse. The flag is zero on the clock after that pulse. A capture in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_mode_i | input | 4 | Compare mode; 4'b1011 enables the special event |
| cmp_val_i | input | 16 | Compare value |
| adc_en_i | input | 1 | Converter enable |
| chan_i | input | 4 | Analog channel select |
| acq_sel_i | input | 3 | Acquisition time code |
| left_just_i | input | 1 | 1 selects left-justified result |
| go_set_i | input | 1 | Software start pulse |
| flag_clr_i | input | 1 | Clears the done flag |
| conv_data_i | input | 10 | Sample from the converter |
| conv_valid_i | input | 1 | Sample valid strobe |
| tmr_o | output | 16 | Timer value |
| go_o | output | 1 | GO / busy bit |
| flag_o | output | 1 | Sticky done flag |
| res_hi_o | output | 8 | Result high byte |
| res_lo_o | output | 8 | Result low byte |
| conv_start_o | output | 1 | One-cycle conversion start |
| conv_chan_o | output | 4 | Channel sent to the converter |

## Verification
The bench sets the compare period shorter than the acquisition window, so special events keep arriving during a conversion. A design that re-armed on those events would issue extra start strobes, and one that gated the timer clear on busy would stop the timer from wrapping. It checks that a disabled converter ignores both start sources while the timer still wraps, and that a software start does not clear the timer. It measures the start-strobe distance for the zero, middle and largest codes, where an off-by-one counter or a wrong table entry shows up as a shifted strobe. It also checks both justifications and the sticky flag against a clear pulse, which catch swapped byte halves and a flag that self-clears.

// File: rtl/cas_pkg.sv
package cas_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_ACQ  = 2'd1,
      SEQ_WAIT = 2'd2
   } seq_st_e;

   localparam logic [3:0] MODE_SPECIAL = 4'b1011;

   // acquisition code to conversion-clock periods
   function automatic logic [4:0] acq_periods(input logic [2:0] code);
      logic [4:0] p;
      if (code <= 3'd4) p = {1'b0, code, 1'b0};
      else              p = 5'd12 + {1'b0, (code - 3'd5), 2'b00};
      return p;
   endfunction

endpackage

// File: rtl/cas_timer.sv
module cas_timer
   import cas_pkg::*;
#(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    mode_i,
   input  logic [TW-1:0] cmp_i,
   output logic [TW-1:0] tmr_o,
   output logic          trig_o
);

   generate
      if (TW < 2) begin : g_bad_tw
         $error("cas_timer: TW must be at least 2");
      end
   endgenerate

   assign trig_o = (mode_i == MODE_SPECIAL) && (tmr_o == cmp_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tmr_o <= '0;
      else if (trig_o) tmr_o <= '0;
      else             tmr_o <= tmr_o + 1'b1;
   end

   a_r2_event_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_SPECIAL && tmr_o == cmp_i) |=> (tmr_o == '0));

   a_r1_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != MODE_SPECIAL) |=> (tmr_o == $past(tmr_o) + 1'b1));

endmodule

// File: rtl/cas_seq.sv
module cas_seq
   import cas_pkg::*;
#(
   parameter int TAD_CYC = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       trig_i,
   input  logic       go_set_i,
   input  logic [2:0] acq_sel_i,
   input  logic       conv_valid_i,
   output logic       go_o,
   output logic       conv_start_o,
   output logic       capture_o
);

   localparam int MAXD = 20 * TAD_CYC;
   localparam int CW   = $clog2(MAXD + 1);

   generate
      if (TAD_CYC < 1) begin : g_bad_tad
         $error("cas_seq: TAD_CYC must be at least 1");
      end
   endgenerate

   seq_st_e        st_q;
   logic [CW-1:0]  cnt_q;
   logic [CW-1:0]  dly_w;
   logic [4:0]     base_w;
   logic           start_w;

   assign base_w = acq_periods(acq_sel_i);

   generate
      if (TAD_CYC == 1) begin : g_unit
         assign dly_w = CW'(base_w);
      end else begin : g_scaled
         assign dly_w = CW'(base_w * TAD_CYC);
      end
   endgenerate

   assign start_w      = en_i && !go_o && (trig_i || go_set_i);
   assign conv_start_o = (st_q == SEQ_ACQ) && (cnt_q == '0);
   assign capture_o    = (st_q == SEQ_WAIT) && conv_valid_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SEQ_IDLE;
         cnt_q <= '0;
         go_o  <= 1'b0;
      end else begin
         case (st_q)
            SEQ_IDLE: if (start_w) begin
               go_o  <= 1'b1;
               cnt_q <= dly_w;
               st_q  <= SEQ_ACQ;
            end
            SEQ_ACQ: begin
               if (cnt_q == '0) st_q  <= SEQ_WAIT;
               else             cnt_q <= cnt_q - 1'b1;
            end
            SEQ_WAIT: if (conv_valid_i) begin
               go_o <= 1'b0;
               st_q <= SEQ_IDLE;
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   a_r3_event_sets_go: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && en_i && !go_o) |=> go_o);

   a_r4_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !go_o) |=> !go_o);

   a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |=> !conv_start_o);

   a_r5_strobe_in_go: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |-> go_o);

   a_r9_go_drops: assert property (@(posedge clk) disable iff (!rst_n)
      capture_o |=> !go_o);

endmodule

// File: rtl/cas_result.sv
module cas_result #(
   parameter int RW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture_i,
   input  logic [RW-1:0] data_i,
   input  logic          left_i,
   input  logic          clr_i,
   output logic [7:0]    hi_o,
   output logic [7:0]    lo_o,
   output logic          flag_o
);

   generate
      if (RW <= 8 || RW >= 16) begin : g_bad_rw
         $error("cas_result: RW must lie between 9 and 15");
      end
   endgenerate

   logic [15:0] just_w;

   always_comb begin
      if (left_i) just_w = {data_i, {(16-RW){1'b0}}};
      else        just_w = {{(16-RW){1'b0}}, data_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_o   <= '0;
         lo_o   <= '0;
         flag_o <= 1'b0;
      end else begin
         if (capture_i) begin
            hi_o <= just_w[15:8];
            lo_o <= just_w[7:0];
         end
         if (capture_i)  flag_o <= 1'b1;
         else if (clr_i) flag_o <= 1'b0;
      end
   end

   a_r9_flag_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i |=> flag_o);

   a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i && !capture_i) |=> (flag_o && $stable(hi_o) && $stable(lo_o)));

endmodule

// File: rtl/cmp_adc_seq.sv
module cmp_adc_seq
   import cas_pkg::*;
#(
   parameter int TW      = 16,
   parameter int RW      = 10,
   parameter int CHW     = 4,
   parameter int TAD_CYC = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [3:0]     cmp_mode_i,
   input  logic [TW-1:0]  cmp_val_i,
   input  logic           adc_en_i,
   input  logic [CHW-1:0] chan_i,
   input  logic [2:0]     acq_sel_i,
   input  logic           left_just_i,
   input  logic           go_set_i,
   input  logic           flag_clr_i,
   input  logic [RW-1:0]  conv_data_i,
   input  logic           conv_valid_i,
   output logic [TW-1:0]  tmr_o,
   output logic           go_o,
   output logic           flag_o,
   output logic [7:0]     res_hi_o,
   output logic [7:0]     res_lo_o,
   output logic           conv_start_o,
   output logic [CHW-1:0] conv_chan_o
);

   logic trig_w;
   logic capture_w;

   cas_timer #(.TW(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (cmp_mode_i),
      .cmp_i  (cmp_val_i),
      .tmr_o  (tmr_o),
      .trig_o (trig_w)
   );

   cas_seq #(.TAD_CYC(TAD_CYC)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (adc_en_i),
      .trig_i       (trig_w),
      .go_set_i     (go_set_i),
      .acq_sel_i    (acq_sel_i),
      .conv_valid_i (conv_valid_i),
      .go_o         (go_o),
      .conv_start_o (conv_start_o),
      .capture_o    (capture_w)
   );

   cas_result #(.RW(RW)) u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture_w),
      .data_i    (conv_data_i),
      .left_i    (left_just_i),
      .clr_i     (flag_clr_i),
      .hi_o      (res_hi_o),
      .lo_o      (res_lo_o),
      .flag_o    (flag_o)
   );

   assign conv_chan_o = chan_i;

   a_r7_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (go_o && !capture_w) |=> go_o);

   a_r6_chan_passes: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |-> (conv_chan_o == chan_i));

endmodule

// File: tb/tb_cmp_adc_seq.sv
module tb_cmp_adc_seq;

   localparam int STUB_LAT = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cmp_mode_i = 4'd0;
   logic [15:0] cmp_val_i = 16'd0;
   logic        adc_en_i = 1'b0;
   logic [3:0]  chan_i = 4'd0;
   logic [2:0]  acq_sel_i = 3'd0;
   logic        left_just_i = 1'b0;
   logic        go_set_i = 1'b0;
   logic        flag_clr_i = 1'b0;
   logic [9:0]  conv_data_i = 10'd0;
   logic        conv_valid_i = 1'b0;
   logic [15:0] tmr_o;
   logic        go_o, flag_o, conv_start_o;
   logic [7:0]  res_hi_o, res_lo_o;
   logic [3:0]  conv_chan_o;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int starts = 0;
   int stub_cnt = 0;

   cmp_adc_seq dut (.*);

   always #5 clk = ~clk;

   // behavioural converter stub
   always @(posedge clk) begin
      if (!rst_n) begin
         conv_valid_i <= 1'b0;
         stub_cnt <= 0;
         starts <= 0;
      end else begin
         conv_valid_i <= 1'b0;
         if (conv_start_o) begin
            stub_cnt <= STUB_LAT;
            starts <= starts + 1;
         end else if (stub_cnt != 0) begin
            stub_cnt <= stub_cnt - 1;
            if (stub_cnt == 1) conv_valid_i <= 1'b1;
         end
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
         finish_run();
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic reset_dut(input logic [3:0] mode, input logic [15:0] cmpv,
                            input logic en, input logic [2:0] sel);
      @(negedge clk);
      rst_n = 1'b0;
      cmp_mode_i = mode;
      cmp_val_i = cmpv;
      adc_en_i = en;
      acq_sel_i = sel;
      go_set_i = 1'b0;
      flag_clr_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic int acq_exp(input int code);
      int t[8] = '{0, 2, 4, 6, 8, 12, 16, 20};
      return t[code];
   endfunction

   task automatic wait_flag(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 200; i++) begin
         if (flag_o) begin ok = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic t_reset_vals();
      reset_dut(4'd0, 16'd100, 1'b0, 3'd0);
      chk(tmr_o == 0, "R1 reset timer", tmr_o, 0);
      chk({go_o, flag_o, res_hi_o, res_lo_o} == 0, "R1 reset go/flag/result",
          {go_o, flag_o, res_hi_o, res_lo_o}, 0);
      repeat (5) @(negedge clk);
      chk(tmr_o == 5, "R1 count", tmr_o, 5);
   endtask

   task automatic t_timer_special();
      bit seen = 1'b0;
      bit go_seen = 1'b0;
      reset_dut(4'b1011, 16'd9, 1'b0, 3'd0);
      for (int i = 0; i < 20 && !seen; i++) begin
         if (go_o) go_seen = 1'b1;
         if (tmr_o == 9) seen = 1'b1;
         else @(negedge clk);
      end
      @(negedge clk);
      chk(tmr_o == 0, "R2 clear on match", tmr_o, 0);
      @(negedge clk);
      chk(tmr_o == 1, "R1 count after clear", tmr_o, 1);
      chk(!go_seen && !go_o && starts == 0, "R4 disabled no go", go_o, 0);
   endtask

   task automatic t_timer_other();
      reset_dut(4'b1010, 16'd9, 1'b1, 3'd0);
      repeat (9) @(negedge clk);
      chk(tmr_o == 9, "R2 other mode at compare", tmr_o, 9);
      @(negedge clk);
      chk(tmr_o == 10, "R2 other mode passes", tmr_o, 10);
      chk(go_o == 0, "R2 other mode no go", go_o, 0);
   endtask

   task automatic t_conv(input int code, input bit left, input logic [9:0] d,
                         input logic [3:0] ch);
      int n = 0;
      bit ok;
      logic [15:0] v;
      left_just_i = left;
      conv_data_i = d;
      chan_i = ch;
      reset_dut(4'b1011, 16'd30, 1'b1, code[2:0]);
      for (int i = 0; i < 100 && !go_o; i++) @(negedge clk);
      chk(go_o == 1, "R3 go set by event", go_o, 1);
      chk(tmr_o == 0, "R3 go with timer clear", tmr_o, 0);
      while (!conv_start_o && n < 100) begin @(negedge clk); n++; end
      chk(n == acq_exp(code), "R5 acquisition delay", n, acq_exp(code));
      chk(conv_chan_o == ch, "R6 channel", conv_chan_o, ch);
      wait_flag(ok);
      chk(ok && go_o == 0, "R9 go clears with flag", go_o, 0);
      v = left ? {d, 6'b0} : {6'b0, d};
      chk(res_hi_o == v[15:8], "R10 high byte", res_hi_o, v[15:8]);
      chk(res_lo_o == v[7:0], "R10 low byte", res_lo_o, v[7:0]);
   endtask

   task automatic t_busy();
      int wraps = 0;
      bit ok;
      conv_data_i = 10'h155;
      left_just_i = 1'b0;
      reset_dut(4'b1011, 16'd4, 1'b1, 3'd7);
      for (int i = 0; i < 20 && !go_o; i++) @(negedge clk);
      for (int i = 0; i < 200 && !flag_o; i++) begin
         @(negedge clk);
         if (tmr_o == 0 && go_o) wraps++;
      end
      ok = flag_o;
      chk(ok && starts == 1, "R7 single start while busy", starts, 1);
      chk(wraps >= 3, "R7 timer clears while busy", wraps, 3);
   endtask

   task automatic t_sw_go();
      bit ok;
      conv_data_i = 10'h0C3;
      left_just_i = 1'b0;
      reset_dut(4'd0, 16'd3, 1'b1, 3'd1);
      repeat (5) @(negedge clk);
      go_set_i = 1'b1;
      @(negedge clk);
      go_set_i = 1'b0;
      chk(go_o == 1, "R8 software start", go_o, 1);
      chk(tmr_o == 6, "R8 timer untouched", tmr_o, 6);
      wait_flag(ok);
      chk(ok && res_lo_o == 8'hC3 && res_hi_o == 8'h00, "R8 software result",
          {res_hi_o, res_lo_o}, 16'h00C3);
      // R11 sticky flag then clear
      repeat (4) @(negedge clk);
      chk(flag_o == 1 && res_lo_o == 8'hC3, "R11 flag sticky", flag_o, 1);
      flag_clr_i = 1'b1;
      @(negedge clk);
      flag_clr_i = 1'b0;
      chk(flag_o == 0, "R11 flag cleared", flag_o, 0);
      chk(res_lo_o == 8'hC3, "R11 result kept after clear", res_lo_o, 8'hC3);
   endtask

   task automatic t_disabled();
      bit bad = 1'b0;
      reset_dut(4'b1011, 16'd6, 1'b0, 3'd0);
      repeat (3) @(negedge clk);
      go_set_i = 1'b1;
      @(negedge clk);
      go_set_i = 1'b0;
      for (int i = 0; i < 20; i++) begin
         if (go_o || tmr_o > 6) bad = 1'b1;
         @(negedge clk);
      end
      chk(!bad && starts == 0 && flag_o == 0, "R4 disabled ignores starts", starts, 0);
   endtask

   initial begin
      t_reset_vals();
      t_timer_special();
      t_timer_other();
      t_conv(0, 1'b0, 10'h2B5, 4'd3);
      t_conv(3, 1'b1, 10'h2B5, 4'd9);
      t_conv(5, 1'b0, 10'h3FF, 4'd12);
      t_conv(7, 1'b1, 10'h001, 4'd15);
      t_busy();
      t_sw_go();
      t_disabled();
      finish_run();
   end

endmodule